// File: doc/BRIEF.md
# Flash Command Window Register Slave

This block is the device-side register window of a flash-style memory that is driven through memory-mapped registers. A host uses a simple synchronous bus to write a command code, a 32-bit target address, a 32-bit data count and a data word. It then writes the start value into a separate execute register. The block models the operation's duration with a programmable busy counter. At the end of the operation it folds externally injected error conditions into a 16-bit device status word. The status error flags stay set until the status register is read, and the read clears them. The host polls that word for completion and errors.

The window also returns fixed identification words, a four-word signature and the program-buffer parameters. It keeps one lock bit per block, and it supports suspend and resume of a program or erase in progress. The bus has no back-pressure: a request is taken on every cycle in which `bus_valid` is high. A read answers with `rd_valid` and `rd_data` exactly one cycle later. A write never produces a response. No storage array is modelled.

Top module: `fcw_cmd_window`

## Requirements
- R1: Constant words are read at these byte addresses:
  - 0x00, 0x02, 0x04 and 0x06 return the signature 0x0050, 0x0046, 0x004F and 0x0057.
  - 0x20 returns the maker ID 0x00A5 and 0x22 returns the device ID 0x2C11.
  - 0x40 returns the buffer offset 0x0400 and 0x42 returns the buffer size 0x0200 words.
- R2: The parameter registers are writable and read back at these addresses: command code 0x80, data 0x84, address low 0x88, address high 0x8A, count low 0x90, count high 0x92.
- R3: A read request is answered with `rd_valid` high and the addressed value on `rd_data` in the next cycle. A write produces no `rd_valid`.
- R4: Writing 0x0001 to the execute register (0xC0) while ready starts the operation named by the command code.
  - Program codes (0x41, 0xE9, 0xC0) and erase (0x20) keep ready low for `busy_cycles` cycles, or 1 cycle if `busy_cycles` is 0.
  - Lock 0x61, unlock 0x62, lock status 0x65, query 0x98 and OTP read 0x97 take one cycle.
  - Any other value written to the execute register is ignored. An unlisted code is also ignored.
- R5: While ready is 0, writes to the parameter registers and to the execute register are ignored.
- R6: Status (0xCC) layout:
  - Bit 1 is protect, bit 2 is program suspended and bit 3 is supply low.
  - Bit 4 is program error, bit 5 is erase error and bit 6 is erase suspended.
  - Bit 7 is ready, bits 9:8 are the region code, bit 12 is the AO failure and bit 15 is available (always 1).
  - All other bits read 0.
  - A status read returns the current value. The cycle after that read, bits 1, 3, 4, 5, 9:8 and 12 (mask 0x133A) are cleared, unless a completion sets them in the same cycle.
- R7: Errors are latched when an operation completes:
  - A program completion latches `inj_supply_low` into bit 3, `inj_prog_err` into bit 4, a non-zero `inj_region` into bits 9:8 and `inj_ao_fail` into bit 12.
  - An erase completion latches bits 3, 5 (from `inj_erase_err`) and 12.
- R8: Locking works per block:
  - The block is address bits [19:16], which are bits 3:0 of address high.
  - Code 0x61 sets that block's lock bit and code 0x62 clears it.
  - Code 0x65 sets status bit 1 if the block is locked.
- R9: A program or erase aimed at a locked block does the following:
  - It keeps ready low for one cycle.
  - It sets status bit 1.
  - It latches no injected error.
- R10: Writing 0x0001 to the suspend register (0xC8) during a busy program or erase has these effects:
  - It freezes the busy counter and raises ready.
  - It sets bit 2 (program) or bit 6 (erase).
  - Outside such an operation, the write is ignored.
- R11: While suspended:
  - An execute with code 0xD0 clears the suspend bit and keeps ready low for the remaining count.
  - Any other execute is ignored.
  - An execute with 0xD0 when not suspended is ignored.
- R12: Writing 0x0001 to the clear-buffer register (0xC4) while ready zeroes the data register. Other values leave it unchanged.
- R13: After reset, status reads 0x8080, every parameter register reads 0, and `dev_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle (always accepted) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 16 | Read data |
| dev_ready | output | 1 | Same as status bit 7 |
| busy_cycles | input | 16 | Modelled duration of program and erase |
| inj_supply_low | input | 1 | Injected supply-low condition |
| inj_prog_err | input | 1 | Injected program failure |
| inj_erase_err | input | 1 | Injected erase failure |
| inj_region | input | 2 | Injected region program status code |
| inj_ao_fail | input | 1 | Injected AO failure |

## Verification
Random program and erase launches use random durations and random injected error sets. The measured busy time tells a frozen counter apart from an off-by-one. The status read tells program errors apart from erase errors. A second read confirms that the flags clear. Directed sequences do four things:
- They lock, query and unlock a block to separate lock state from protect reporting.
- They suspend a program part-way and an erase at once, then check that resume continues from the remaining count rather than restarting.
- They try execute values other than 0x0001, unlisted codes and writes during busy, each of which must leave the registers and ready untouched.
- They read back random values from every parameter register.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  localparam logic [7:0] OFS_SIG0   = 8'h00;
  localparam logic [7:0] OFS_SIG1   = 8'h02;
  localparam logic [7:0] OFS_SIG2   = 8'h04;
  localparam logic [7:0] OFS_SIG3   = 8'h06;
  localparam logic [7:0] OFS_MFR    = 8'h20;
  localparam logic [7:0] OFS_DEV    = 8'h22;
  localparam logic [7:0] OFS_BUFOFS = 8'h40;
  localparam logic [7:0] OFS_BUFSZ  = 8'h42;
  localparam logic [7:0] OFS_CODE   = 8'h80;
  localparam logic [7:0] OFS_DATA   = 8'h84;
  localparam logic [7:0] OFS_ADRL   = 8'h88;
  localparam logic [7:0] OFS_ADRH   = 8'h8A;
  localparam logic [7:0] OFS_CNTL   = 8'h90;
  localparam logic [7:0] OFS_CNTH   = 8'h92;
  localparam logic [7:0] OFS_EXEC   = 8'hC0;
  localparam logic [7:0] OFS_CLRBUF = 8'hC4;
  localparam logic [7:0] OFS_SUSP   = 8'hC8;
  localparam logic [7:0] OFS_STAT   = 8'hCC;

  // parameter register slots, in index order
  localparam int NUM_PREG = 6;
  localparam int IDX_CODE = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_ADRL = 2;
  localparam int IDX_ADRH = 3;
  localparam int IDX_CNTL = 4;
  localparam int IDX_CNTH = 5;
  localparam logic [NUM_PREG*8-1:0] PREG_OFS =
    {OFS_CNTH, OFS_CNTL, OFS_ADRH, OFS_ADRL, OFS_DATA, OFS_CODE};

  localparam logic [15:0] GO_VALUE = 16'h0001;

  localparam logic [15:0] CMD_WPROG   = 16'h0041;
  localparam logic [15:0] CMD_BPROG   = 16'h00E9;
  localparam logic [15:0] CMD_ERASE   = 16'h0020;
  localparam logic [15:0] CMD_LOCK    = 16'h0061;
  localparam logic [15:0] CMD_UNLOCK  = 16'h0062;
  localparam logic [15:0] CMD_LKSTAT  = 16'h0065;
  localparam logic [15:0] CMD_QUERY   = 16'h0098;
  localparam logic [15:0] CMD_OTPRD   = 16'h0097;
  localparam logic [15:0] CMD_OTPPROG = 16'h00C0;
  localparam logic [15:0] CMD_RESUME  = 16'h00D0;

  localparam int ST_PROT  = 1;
  localparam int ST_PSUSP = 2;
  localparam int ST_VLOW  = 3;
  localparam int ST_PERR  = 4;
  localparam int ST_EERR  = 5;
  localparam int ST_ESUSP = 6;
  localparam int ST_READY = 7;
  localparam int ST_REGN  = 8;
  localparam int ST_AO    = 12;
  localparam int ST_AVAIL = 15;
  localparam logic [15:0] ST_CLR_MASK = 16'h133A;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_ERASE, OP_LOCK, OP_UNLOCK, OP_LKSTAT, OP_QUIET, OP_DENIED
  } op_kind_e;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_SUSP} eng_state_e;

  function automatic op_kind_e decode_op(input logic [15:0] code);
    case (code)
      CMD_WPROG, CMD_BPROG, CMD_OTPPROG: return OP_PROG;
      CMD_ERASE:                         return OP_ERASE;
      CMD_LOCK:                          return OP_LOCK;
      CMD_UNLOCK:                        return OP_UNLOCK;
      CMD_LKSTAT:                        return OP_LKSTAT;
      CMD_QUERY, CMD_OTPRD:              return OP_QUIET;
      default:                           return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fcw_param_regs.sv
module fcw_param_regs
  import fcw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_data,
  output logic [DW-1:0] code_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] adr_lo_o,
  output logic [DW-1:0] adr_hi_o,
  output logic [DW-1:0] cnt_lo_o,
  output logic [DW-1:0] cnt_hi_o
);

  logic [NUM_PREG-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NUM_PREG; i++) begin : g_reg
    localparam logic [7:0] MY_OFS = PREG_OFS[i*8 +: 8];
    localparam bit CLEARABLE = (i == IDX_DATA);
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (wr_en && wr_addr == MY_OFS)
        regs_q[i] <= wr_data;
      else if (CLEARABLE && clr_data)
        regs_q[i] <= '0;
    end
  end

  assign code_o   = regs_q[IDX_CODE];
  assign data_o   = regs_q[IDX_DATA];
  assign adr_lo_o = regs_q[IDX_ADRL];
  assign adr_hi_o = regs_q[IDX_ADRH];
  assign cnt_lo_o = regs_q[IDX_CNTL];
  assign cnt_hi_o = regs_q[IDX_CNTH];

endmodule

// File: rtl/fcw_op_engine.sv
module fcw_op_engine
  import fcw_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_go,
  input  logic             susp_go,
  input  logic             stat_rd,
  input  logic [15:0]      code_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [CNT_W-1:0] busy_cycles_i,
  input  logic             inj_vlow,
  input  logic             inj_perr,
  input  logic             inj_eerr,
  input  logic [1:0]       inj_region,
  input  logic             inj_ao,
  output logic [15:0]      status_o,
  output logic             ready_o,
  output logic             done_o
);

  localparam int NUM_BLK = 1 << BLK_W;

  eng_state_e       state_q;
  op_kind_e         kind_q, kind_new, kind_eff;
  logic [CNT_W-1:0] cnt_q, cnt_load;
  logic [BLK_W-1:0] blk_q;
  logic [NUM_BLK-1:0] lock_q;
  logic prot_q, vlow_q, perr_q, eerr_q, ao_q;
  logic [1:0] region_q;
  logic start, resume, susp_take, pe_q, pe_new;

  assign kind_new = decode_op(code_i);
  assign pe_new   = (kind_new == OP_PROG) || (kind_new == OP_ERASE);
  assign kind_eff = (pe_new && lock_q[blk_i]) ? OP_DENIED : kind_new;
  assign cnt_load = ((kind_eff == OP_PROG) || (kind_eff == OP_ERASE))
                    ? ((busy_cycles_i == '0) ? CNT_W'(1) : busy_cycles_i)
                    : CNT_W'(1);
  assign pe_q      = (kind_q == OP_PROG) || (kind_q == OP_ERASE);
  assign start     = exec_go && state_q == S_IDLE && kind_new != OP_NONE;
  assign resume    = exec_go && state_q == S_SUSP && code_i == CMD_RESUME;
  assign susp_take = susp_go && state_q == S_BUSY && pe_q;
  assign done_o    = state_q == S_BUSY && !susp_take && cnt_q == CNT_W'(1);
  assign ready_o   = state_q != S_BUSY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      kind_q  <= OP_NONE;
      blk_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_BUSY;
          cnt_q   <= cnt_load;
          kind_q  <= kind_eff;
          blk_q   <= blk_i;
        end
        S_BUSY: begin
          if (susp_take)            state_q <= S_SUSP;
          else if (cnt_q == CNT_W'(1)) state_q <= S_IDLE;
          else                      cnt_q   <= cnt_q - CNT_W'(1);
        end
        S_SUSP: if (resume) state_q <= S_BUSY;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lock_q <= '0;
    else if (done_o && kind_q == OP_LOCK)
      lock_q[blk_q] <= 1'b1;
    else if (done_o && kind_q == OP_UNLOCK)
      lock_q[blk_q] <= 1'b0;
  end

  // sticky error flags: a completion sets, a status read clears, set wins
  logic set_prot, set_vlow, set_perr, set_eerr, set_ao, set_regn;
  assign set_prot = done_o && (kind_q == OP_DENIED || (kind_q == OP_LKSTAT && lock_q[blk_q]));
  assign set_vlow = done_o && pe_q && inj_vlow;
  assign set_perr = done_o && kind_q == OP_PROG && inj_perr;
  assign set_eerr = done_o && kind_q == OP_ERASE && inj_eerr;
  assign set_ao   = done_o && pe_q && inj_ao;
  assign set_regn = done_o && kind_q == OP_PROG && inj_region != 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {prot_q, vlow_q, perr_q, eerr_q, ao_q} <= '0;
      region_q <= 2'b00;
    end else begin
      prot_q   <= set_prot | (prot_q & ~stat_rd);
      vlow_q   <= set_vlow | (vlow_q & ~stat_rd);
      perr_q   <= set_perr | (perr_q & ~stat_rd);
      eerr_q   <= set_eerr | (eerr_q & ~stat_rd);
      ao_q     <= set_ao   | (ao_q   & ~stat_rd);
      region_q <= set_regn ? inj_region : (stat_rd ? 2'b00 : region_q);
    end
  end

  always_comb begin
    status_o = '0;
    status_o[ST_PROT]  = prot_q;
    status_o[ST_PSUSP] = state_q == S_SUSP && kind_q == OP_PROG;
    status_o[ST_VLOW]  = vlow_q;
    status_o[ST_PERR]  = perr_q;
    status_o[ST_EERR]  = eerr_q;
    status_o[ST_ESUSP] = state_q == S_SUSP && kind_q == OP_ERASE;
    status_o[ST_READY] = ready_o;
    status_o[ST_REGN +: 2] = region_q;
    status_o[ST_AO]    = ao_q;
    status_o[ST_AVAIL] = 1'b1;
  end

endmodule

// File: rtl/fcw_cmd_window.sv
module fcw_cmd_window
  import fcw_pkg::*;
#(
  parameter logic [63:0] SIG_WORDS = {16'h0057, 16'h004F, 16'h0046, 16'h0050},
  parameter logic [15:0] MFR_ID    = 16'h00A5,
  parameter logic [15:0] DEV_ID    = 16'h2C11,
  parameter logic [15:0] BUF_OFS   = 16'h0400,
  parameter logic [15:0] BUF_WORDS = 16'h0200,
  parameter int BLK_W   = 4,
  parameter int BLK_LSB = 16,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [7:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             dev_ready,
  input  logic [CNT_W-1:0] busy_cycles,
  input  logic             inj_supply_low,
  input  logic             inj_prog_err,
  input  logic             inj_erase_err,
  input  logic [1:0]       inj_region,
  input  logic             inj_ao_fail
);

  logic [15:0] code_q, data_q, adr_lo_q, adr_hi_q, cnt_lo_q, cnt_hi_q;
  logic [15:0] stat_w, rd_mux;
  logic [BLK_W-1:0] blk_idx;
  logic wr_acc, is_go, param_wr, exec_go, susp_go, clr_data, stat_rd, op_done;

  assign wr_acc   = bus_valid && bus_write;
  assign is_go    = bus_wdata == GO_VALUE;
  assign param_wr = wr_acc && dev_ready;
  assign exec_go  = param_wr && bus_addr == OFS_EXEC && is_go;
  assign clr_data = param_wr && bus_addr == OFS_CLRBUF && is_go;
  assign susp_go  = wr_acc && bus_addr == OFS_SUSP && is_go;
  assign stat_rd  = bus_valid && !bus_write && bus_addr == OFS_STAT;
  assign blk_idx  = BLK_W'({adr_hi_q, adr_lo_q} >> BLK_LSB);

  fcw_param_regs #(.DW(16)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(param_wr), .wr_addr(bus_addr), .wr_data(bus_wdata), .clr_data(clr_data),
    .code_o(code_q), .data_o(data_q), .adr_lo_o(adr_lo_q), .adr_hi_o(adr_hi_q),
    .cnt_lo_o(cnt_lo_q), .cnt_hi_o(cnt_hi_q)
  );

  fcw_op_engine #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .exec_go(exec_go), .susp_go(susp_go), .stat_rd(stat_rd),
    .code_i(code_q), .blk_i(blk_idx), .busy_cycles_i(busy_cycles),
    .inj_vlow(inj_supply_low), .inj_perr(inj_prog_err), .inj_eerr(inj_erase_err),
    .inj_region(inj_region), .inj_ao(inj_ao_fail),
    .status_o(stat_w), .ready_o(dev_ready), .done_o(op_done)
  );

  always_comb begin
    case (bus_addr)
      OFS_SIG0:   rd_mux = SIG_WORDS[15:0];
      OFS_SIG1:   rd_mux = SIG_WORDS[31:16];
      OFS_SIG2:   rd_mux = SIG_WORDS[47:32];
      OFS_SIG3:   rd_mux = SIG_WORDS[63:48];
      OFS_MFR:    rd_mux = MFR_ID;
      OFS_DEV:    rd_mux = DEV_ID;
      OFS_BUFOFS: rd_mux = BUF_OFS;
      OFS_BUFSZ:  rd_mux = BUF_WORDS;
      OFS_CODE:   rd_mux = code_q;
      OFS_DATA:   rd_mux = data_q;
      OFS_ADRL:   rd_mux = adr_lo_q;
      OFS_ADRH:   rd_mux = adr_hi_q;
      OFS_CNTL:   rd_mux = cnt_lo_q;
      OFS_CNTH:   rd_mux = cnt_hi_q;
      OFS_STAT:   rd_mux = stat_w;
      default:    rd_mux = 16'h0000;
    endcase
  end

  // read data captured here; the status clear lands on the same edge,
  // so the returned word is the pre-clear value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/fcw_cmd_window_chk.sv
module fcw_cmd_window_chk
  import fcw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [7:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        dev_ready,
  input logic [15:0] status,
  input logic [15:0] code_q,
  input logic        done
);

  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  p_write_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !rd_valid);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_EXEC && bus_wdata == GO_VALUE && dev_ready
     && !status[ST_PSUSP] && !status[ST_ESUSP]
     && (code_q == CMD_WPROG || code_q == CMD_BPROG || code_q == CMD_ERASE || code_q == CMD_OTPPROG))
    |=> !dev_ready);

  p_params_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ready |=> $stable(code_q));

  p_status_snapshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_STAT) |=> rd_data == $past(status));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_STAT && !done) |=> (status & ST_CLR_MASK) == 16'h0000);

  p_susp_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_PSUSP] || status[ST_ESUSP]) |-> dev_ready);

  p_susp_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_PSUSP] && status[ST_ESUSP]));

endmodule

bind fcw_cmd_window fcw_cmd_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
  .dev_ready(dev_ready), .status(stat_w), .code_q(code_q), .done(op_done)
);

// File: tb/fcw_cmd_window_tb.sv
`timescale 1ns/1ps
module fcw_cmd_window_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic rd_valid, dev_ready;
  logic [15:0] rd_data;
  logic [15:0] busy_cycles = 16'd1;
  logic inj_supply_low = 0, inj_prog_err = 0, inj_erase_err = 0, inj_ao_fail = 0;
  logic [1:0] inj_region = 2'b00;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fcw_cmd_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dev_ready(dev_ready), .busy_cycles(busy_cycles), .inj_supply_low(inj_supply_low),
    .inj_prog_err(inj_prog_err), .inj_erase_err(inj_erase_err),
    .inj_region(inj_region), .inj_ao_fail(inj_ao_fail)
  );

  localparam logic [7:0] A_CODE = 8'h80, A_DATA = 8'h84, A_ADRL = 8'h88, A_ADRH = 8'h8A;
  localparam logic [7:0] A_CNTL = 8'h90, A_CNTH = 8'h92, A_EXEC = 8'hC0, A_CLR = 8'hC4;
  localparam logic [7:0] A_SUSP = 8'hC8, A_STAT = 8'hCC;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = rd_data;
    chk("R3 rd_valid", {15'd0, rd_valid}, 16'd1);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!dev_ready && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [15:0] code, output int n);
    wr(A_CODE, code);
    wr(A_EXEC, 16'h0001);
    wait_busy(n);
  endtask

  function automatic logic [15:0] exp_stat(input bit erase, input bit vl, input bit pe,
                                           input bit ee, input logic [1:0] rg, input bit ao);
    logic [15:0] s = 16'h8080;
    s[3] = vl;
    s[12] = ao;
    if (erase) s[5] = ee;
    else begin
      s[4] = pe;
      s[9:8] = rg;
    end
    return s;
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13 reset state
    chk("R13 ready", {15'd0, dev_ready}, 16'd1);
    rd(A_STAT, d); chk("R13 status", d, 16'h8080);
    rd(A_CODE, d); chk("R13 code", d, 16'h0000);
    rd(A_CNTH, d); chk("R13 count high", d, 16'h0000);

    // R1 constants
    rd(8'h00, d); chk("R1 sig0", d, 16'h0050);
    rd(8'h02, d); chk("R1 sig1", d, 16'h0046);
    rd(8'h04, d); chk("R1 sig2", d, 16'h004F);
    rd(8'h06, d); chk("R1 sig3", d, 16'h0057);
    rd(8'h20, d); chk("R1 maker", d, 16'h00A5);
    rd(8'h22, d); chk("R1 device", d, 16'h2C11);
    rd(8'h40, d); chk("R1 bufofs", d, 16'h0400);
    rd(8'h42, d); chk("R1 bufsize", d, 16'h0200);

    // R3 a write gives no response
    wr(A_CNTL, 16'h0003);
    chk("R3 write silent", {15'd0, rd_valid}, 16'd0);

    // R2 random readback
    for (int i = 0; i < 30; i++) begin
      logic [7:0] a;
      logic [15:0] v;
      case ($urandom_range(0, 5))
        0: a = A_CODE; 1: a = A_DATA; 2: a = A_ADRL;
        3: a = A_ADRH; 4: a = A_CNTL; default: a = A_CNTH;
      endcase
      v = 16'($urandom);
      wr(a, v);
      rd(a, d);
      chk("R2 readback", d, v);
    end
    wr(A_ADRL, 16'h0000); wr(A_ADRH, 16'h0000);

    // R12 clear buffer
    wr(A_DATA, 16'h1234);
    wr(A_CLR, 16'h0002);
    rd(A_DATA, d); chk("R12 other value ignored", d, 16'h1234);
    wr(A_CLR, 16'h0001);
    rd(A_DATA, d); chk("R12 cleared", d, 16'h0000);

    // R4 execute rules
    busy_cycles = 16'd5;
    wr(A_CODE, 16'h0041);
    wr(A_EXEC, 16'h0002);
    chk("R4 exec value ignored", {15'd0, dev_ready}, 16'd1);
    wr(A_EXEC, 16'h0001);
    wait_busy(n); chk("R4 program busy", 16'(n), 16'd5);
    busy_cycles = 16'd0;
    run_op(16'h0020, n); chk("R4 zero busy -> 1", 16'(n), 16'd1);
    run_op(16'h0098, n); chk("R4 query one cycle", 16'(n), 16'd1);
    run_op(16'h0033, n); chk("R4 unknown code ignored", 16'(n), 16'd0);
    rd(A_STAT, d); chk("R4 status clean", d, 16'h8080);

    // R5 writes during busy ignored
    busy_cycles = 16'd8;
    wr(A_CODE, 16'h0041);
    wr(A_EXEC, 16'h0001);
    wr(A_CODE, 16'h0055);
    wr(A_ADRL, 16'h7777);
    wr(A_EXEC, 16'h0001);
    wait_busy(n);
    @(negedge clk);
    chk("R5 no relaunch", {15'd0, dev_ready}, 16'd1);
    rd(A_CODE, d); chk("R5 code kept", d, 16'h0041);
    rd(A_ADRL, d); chk("R5 addr kept", d, 16'h0000);

    // R7 / R6 random program and erase with injections
    for (int i = 0; i < 16; i++) begin
      logic [15:0] code;
      int sel, len;
      bit vl, pe, ee, ao;
      logic [1:0] rg;
      sel = $urandom_range(0, 3);
      code = (sel == 3) ? 16'h0020 : (sel == 0) ? 16'h0041 : (sel == 1) ? 16'h00E9 : 16'h00C0;
      len = $urandom_range(1, 16);
      vl = 1'($urandom); pe = 1'($urandom); ee = 1'($urandom); ao = 1'($urandom);
      rg = 2'($urandom);
      busy_cycles = 16'(len);
      inj_supply_low = vl; inj_prog_err = pe; inj_erase_err = ee; inj_ao_fail = ao;
      inj_region = rg;
      run_op(code, n);
      chk("R4 random busy", 16'(n), 16'(len));
      rd(A_STAT, d);
      chk("R7 injected status", d, exp_stat(sel == 3, vl, pe, ee, rg, ao));
      {inj_supply_low, inj_prog_err, inj_erase_err, inj_ao_fail} = 4'b0000;
      inj_region = 2'b00;
      rd(A_STAT, d);
      chk("R6 read cleared", d, 16'h8080);
    end

    // R8 / R9 locking
    wr(A_ADRH, 16'h0003);
    run_op(16'h0061, n); chk("R8 lock one cycle", 16'(n), 16'd1);
    rd(A_STAT, d); chk("R8 lock sets no protect", d, 16'h8080);
    run_op(16'h0065, n);
    rd(A_STAT, d); chk("R8 lock status locked", d, 16'h8082);
    rd(A_STAT, d); chk("R6 protect cleared", d, 16'h8080);
    busy_cycles = 16'd9; inj_prog_err = 1;
    run_op(16'h0041, n); chk("R9 denied one cycle", 16'(n), 16'd1);
    rd(A_STAT, d); chk("R9 protect only", d, 16'h8082);
    inj_prog_err = 0;
    run_op(16'h0062, n);
    run_op(16'h0065, n);
    rd(A_STAT, d); chk("R8 unlocked", d, 16'h8080);
    run_op(16'h0020, n); chk("R9 erase after unlock", 16'(n), 16'd9);
    wr(A_ADRH, 16'h0000);

    // R10 / R11 suspend and resume
    busy_cycles = 16'd10;
    wr(A_CODE, 16'h0041);
    wr(A_EXEC, 16'h0001);
    repeat (3) @(negedge clk);
    wr(A_SUSP, 16'h0001);
    chk("R10 ready in suspend", {15'd0, dev_ready}, 16'd1);
    rd(A_STAT, d); chk("R10 program suspended", d, 16'h8084);
    run_op(16'h0020, n); chk("R11 other exec ignored", 16'(n), 16'd0);
    rd(A_STAT, d); chk("R11 still suspended", d, 16'h8084);
    run_op(16'h00D0, n); chk("R11 resume remaining", 16'(n), 16'd7);
    rd(A_STAT, d); chk("R11 suspend cleared", d, 16'h8080);

    busy_cycles = 16'd6;
    wr(A_CODE, 16'h0020);
    wr(A_EXEC, 16'h0001);
    wr(A_SUSP, 16'h0001);
    rd(A_STAT, d); chk("R10 erase suspended", d, 16'h80C0);
    run_op(16'h00D0, n); chk("R11 erase resume", 16'(n), 16'd6);

    wr(A_SUSP, 16'h0001);
    rd(A_STAT, d); chk("R10 idle suspend ignored", d, 16'h8080);
    run_op(16'h00D0, n); chk("R11 idle resume ignored", 16'(n), 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule